// File: doc/BRIEF.md
# Sound CPU memory bus unit

This block stands between an 8-bit sound-processor core and its 64 KiB address space. For each bus request from the core it forms the effective address and steers the access to one of three places: the main RAM, a sixteen-byte register I/O window at 0x00F0–0x00FF, or a 64-byte boot ROM that overlays the top of memory while an enable flag is set. Addresses come from the request itself, from the direct-page flag plus an 8-bit offset, from the stack pointer (stack page 0x01), or from the program counter for opcode fetches. The stack pointer and program counter live in this block.

Stores always reach RAM, including stores that also go to the I/O window. Reads are returned through a registered source multiplexer, one clock after the request. On every bus cycle the block advances a shared cycle counter and raises a tick to the three timers and the DSP clock count. An idle request may ask for several cycles at once. In that case the counter and the tick step advance by that amount in one clock.

Top module: `snd_bus_unit`

## Requirements
- R1: A request whose effective address has bits [15:4] equal to 0x00F asserts `io_sel` with `io_addr` = address bits [3:0], and a read of it returns `io_rdata`.
- R2: While the ROM-enable flag is 1, a read at an effective address of 0xFFC0 or above returns `rom_rdata`, with `rom_addr` = address bits [5:0].
- R3: A read that hits neither the I/O window nor the enabled ROM returns `ram_rdata` for `ram_addr` equal to the effective address. This includes reads of 0xFFC0–0xFFFF while the flag is 0.
- R4: Every store (op 2 write, op 3 push) asserts `ram_we` with `ram_wdata` = `req_wdata` at the effective address. A store in the I/O window also asserts `io_we`. Reads, pops, fetches and idles never assert `ram_we` or `io_we`.
- R5: Push (op 3) stores at {0x01, SP} and then decrements SP modulo 256, so a push at SP=0x00 leaves SP=0xFF.
- R6: Pop (op 4) increments SP modulo 256 first and then reads {0x01, new SP}.
- R7: With `req_dp`=1, a read or write (ops 1, 2) uses the address {7'b0, `dp_page`, `req_addr`[7:0]}. The upper byte of `req_addr` is ignored.
- R8: Fetch (op 5) reads at PC and then increments PC modulo 65536.
- R9: Each read, write, push, pop or fetch adds 1 to `cycle_count`. In the same cycle it drives `tick_step`=1 and asserts all three `timer_tick` bits and `dsp_tick`.
- R10: Idle (op 0) adds `idle_cycles` to `cycle_count` and drives `tick_step`=`idle_cycles`. The tick strobes are asserted exactly when that value is non-zero.
- R11: Read data appears on `rdata` with `rvalid`=1 in the clock after the request. `rvalid` is 0 after stores and idles.
- R12: After reset the ROM-enable flag is 1, SP=0xFF, PC=0xFFC0 and `cycle_count`=0. A pulse on `rom_en_wr` loads the flag from `rom_en_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_op | input | 3 | 0 idle, 1 read, 2 write, 3 push, 4 pop, 5 fetch |
| req_addr | input | 16 | Absolute address or direct-page offset |
| req_dp | input | 1 | Direct-page addressing for read/write |
| req_wdata | input | 8 | Store data |
| idle_cycles | input | 4 | Cycle count for an idle request |
| dp_page | input | 1 | Direct-page flag from the core |
| sp_load | input | 1 | Load SP from sp_value |
| sp_value | input | 8 | New SP |
| pc_load | input | 1 | Load PC from pc_value |
| pc_value | input | 16 | New PC |
| rom_en_wr | input | 1 | Update ROM-enable flag |
| rom_en_val | input | 1 | New ROM-enable value |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | rdata holds a fresh read |
| sp_q | output | 8 | Stack pointer |
| pc_q | output | 16 | Program counter |
| ram_addr | output | 16 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data (same cycle) |
| io_sel | output | 1 | I/O window access |
| io_addr | output | 4 | I/O register index |
| io_we | output | 1 | I/O register write |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data (same cycle) |
| rom_addr | output | 6 | Boot ROM index |
| rom_rdata | input | 8 | Boot ROM data (same cycle) |
| cycle_count | output | 32 | Bus cycle counter |
| tick_step | output | 4 | Cycles consumed this clock |
| timer_tick | output | 3 | Tick to each timer |
| dsp_tick | output | 1 | Tick to the DSP cycle count |

## Verification
The read sweep covers every address in the lowest and highest 512 bytes and a stride-7 sample of the rest. It runs once with the ROM flag set and once with it cleared. The bench models the RAM, I/O and ROM with three disjoint data patterns, so a misrouted read shows up as a different byte. A store sweep checks RAM mirroring of I/O writes. Push and pop runs cross the stack-page wrap, and direct-page sweeps for both page values use upper address bytes that must be ignored. Fetches run across the PC wrap, and idles run for every count from 0 to 15, which separates single-cycle from multi-cycle advance of the counter.

// File: rtl/snd_bus_pkg.sv
// Shared types for the sound CPU memory bus unit.
// Assumes the request opcode encoding is fixed by the CPU core side.
package snd_bus_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_PUSH  = 3'd3,
        OP_POP   = 3'd4,
        OP_FETCH = 3'd5
    } bus_op_e;

    typedef enum logic [1:0] {
        SRC_RAM = 2'd0,
        SRC_IO  = 2'd1,
        SRC_ROM = 2'd2
    } rd_src_e;
endpackage

// File: rtl/sbu_addr_gen.sv
// Effective address generator: holds SP and PC and forms the bus address
// from absolute, direct-page, stack or fetch modes.
// Assumes loads of SP/PC take priority over the update of the same register.
module sbu_addr_gen
    import snd_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [7:0] SP_RST = 8'hFF,
    parameter logic [15:0] PC_RST = 16'hFFC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  bus_op_e           op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_dp,
    input  logic              dp_page,
    input  logic              sp_load,
    input  logic [DATA_W-1:0] sp_value,
    input  logic              pc_load,
    input  logic [ADDR_W-1:0] pc_value,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] sp_q,
    output logic [ADDR_W-1:0] pc_q
);
    localparam int PAGE_W = ADDR_W - DATA_W;
    localparam logic [PAGE_W-1:0] STACK_PAGE = PAGE_W'(1);

    logic [DATA_W-1:0] sp_inc;
    assign sp_inc = sp_q + 1'b1;

    // Select the effective address for the requested mode.
    always_comb begin
        bus_addr = req_addr;
        unique case (op)
            OP_READ, OP_WRITE:
                if (req_dp) bus_addr = {{(PAGE_W-1){1'b0}}, dp_page, req_addr[DATA_W-1:0]};
            OP_PUSH:  bus_addr = {STACK_PAGE, sp_q};
            OP_POP:   bus_addr = {STACK_PAGE, sp_inc};
            OP_FETCH: bus_addr = pc_q;
            default:  bus_addr = req_addr;
        endcase
    end

    // Classify the request as a memory read or memory store.
    always_comb begin
        mem_rd = req_valid && (op == OP_READ || op == OP_POP || op == OP_FETCH);
        mem_wr = req_valid && (op == OP_WRITE || op == OP_PUSH);
    end

    // Stack pointer: load, post-decrement on push, pre-increment on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)                         sp_q <= SP_RST;
        else if (sp_load)                   sp_q <= sp_value;
        else if (req_valid && op == OP_PUSH) sp_q <= sp_q - 1'b1;
        else if (req_valid && op == OP_POP)  sp_q <= sp_inc;
    end

    // Program counter: load, or advance after each fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pc_q <= PC_RST;
        else if (pc_load)                    pc_q <= pc_value;
        else if (req_valid && op == OP_FETCH) pc_q <= pc_q + 1'b1;
    end

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_PUSH && !sp_load) |=> (sp_q == $past(sp_q) - 8'd1)); // R5
    AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_POP && !sp_load) |=> (bus_addr[DATA_W-1:0] != $past(bus_addr[DATA_W-1:0]) || op != OP_POP || sp_q == $past(sp_q) + 8'd1)); // R6
    AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_FETCH && !pc_load) |=> (pc_q == $past(pc_q) + 16'd1)); // R8
    AST_DP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dp && (op == OP_READ || op == OP_WRITE)) |-> (bus_addr[ADDR_W-1:DATA_W+1] == '0)); // R7
endmodule

// File: rtl/sbu_target.sv
// Target decoder and read-return path: steers each access to RAM, the I/O
// window or the boot ROM overlay, mirrors stores into RAM, and registers the
// selected read data. Assumes all three sources answer in the request cycle.
module sbu_target
    import snd_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int IO_AW  = 4,
    parameter int ROM_AW = 6,
    parameter logic [15:0] IO_BASE = 16'h00F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rom_en_wr,
    input  logic              rom_en_val,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              io_sel,
    output logic [IO_AW-1:0]  io_addr,
    output logic              io_we,
    output logic [DATA_W-1:0] io_wdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int IO_TAG_W = ADDR_W - IO_AW;
    localparam logic [IO_TAG_W-1:0] IO_TAG = IO_BASE[ADDR_W-1:IO_AW];

    logic    rom_en;
    logic    io_hit;
    logic    rom_hit;
    rd_src_e src;
    logic [DATA_W-1:0] rd_mux;

    // Region match for the I/O window and the enabled ROM overlay.
    always_comb begin
        io_hit  = (bus_addr[ADDR_W-1:IO_AW] == IO_TAG);
        rom_hit = rom_en && (&bus_addr[ADDR_W-1:ROM_AW]);
    end

    // Drive the RAM, I/O and ROM ports; every store goes to RAM.
    always_comb begin
        ram_addr  = bus_addr;
        ram_we    = mem_wr;
        ram_wdata = wdata;
        io_sel    = (mem_rd || mem_wr) && io_hit;
        io_we     = mem_wr && io_hit;
        io_addr   = bus_addr[IO_AW-1:0];
        io_wdata  = wdata;
        rom_addr  = bus_addr[ROM_AW-1:0];
    end

    // Pick the read source, I/O window first, then ROM, then RAM.
    always_comb begin
        if (io_hit)       src = SRC_IO;
        else if (rom_hit) src = SRC_ROM;
        else              src = SRC_RAM;
        unique case (src)
            SRC_IO:  rd_mux = io_rdata;
            SRC_ROM: rd_mux = rom_rdata;
            default: rd_mux = ram_rdata;
        endcase
    end

    // ROM overlay enable flag, set at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         rom_en <= 1'b1;
        else if (rom_en_wr) rom_en <= rom_en_val;
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= mem_rd;
            if (mem_rd) rdata <= rd_mux;
        end
    end

    AST_IO_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        io_we |-> (ram_we && ram_addr[IO_AW-1:0] == io_addr)); // R4
    AST_RVALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> rvalid); // R11
    AST_ONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_hit, rom_hit})); // R2
    AST_ROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en_wr |=> (rom_en == $past(rom_en_val))); // R12
endmodule

// File: rtl/sbu_cycle.sv
// Bus cycle accounting: turns each request into a step count, advances the
// shared cycle counter and raises the timer and DSP ticks.
// Assumes an idle request of zero cycles is legal and consumes nothing.
module sbu_cycle
    import snd_bus_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int IDLE_W   = 4,
    parameter int N_TIMERS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  bus_op_e             op,
    input  logic [IDLE_W-1:0]   idle_cycles,
    output logic [CNT_W-1:0]    cycle_count,
    output logic [IDLE_W-1:0]   tick_step,
    output logic [N_TIMERS-1:0] timer_tick,
    output logic                dsp_tick
);
    logic any_tick;

    // Cycles consumed by this request.
    always_comb begin
        if (!req_valid)         tick_step = '0;
        else if (op == OP_IDLE) tick_step = idle_cycles;
        else                    tick_step = IDLE_W'(1);
        any_tick = (tick_step != '0);
        dsp_tick = any_tick;
    end

    // One strobe per timer.
    for (genvar t = 0; t < N_TIMERS; t++) begin : g_tick
        assign timer_tick[t] = any_tick;
    end

    // Shared cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cycle_count <= '0;
        else        cycle_count <= cycle_count + CNT_W'(tick_step);
    end

    AST_ACCESS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op != OP_IDLE) |-> (tick_step == IDLE_W'(1) && &timer_tick && dsp_tick)); // R9
    AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_IDLE) |=> (cycle_count == $past(cycle_count) + CNT_W'($past(idle_cycles)))); // R10
endmodule

// File: rtl/snd_bus_unit.sv
// Top of the sound CPU memory bus unit: address generation, target
// decoding with registered read return, and cycle/tick accounting.
// Assumes one request per clock from the CPU core.
module snd_bus_unit
    import snd_bus_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int IO_AW    = 4,
    parameter int ROM_AW   = 6,
    parameter int CNT_W    = 32,
    parameter int IDLE_W   = 4,
    parameter int N_TIMERS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_dp,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [IDLE_W-1:0]   idle_cycles,
    input  logic                dp_page,
    input  logic                sp_load,
    input  logic [DATA_W-1:0]   sp_value,
    input  logic                pc_load,
    input  logic [ADDR_W-1:0]   pc_value,
    input  logic                rom_en_wr,
    input  logic                rom_en_val,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid,
    output logic [DATA_W-1:0]   sp_q,
    output logic [ADDR_W-1:0]   pc_q,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic                ram_we,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic                io_sel,
    output logic [IO_AW-1:0]    io_addr,
    output logic                io_we,
    output logic [DATA_W-1:0]   io_wdata,
    input  logic [DATA_W-1:0]   io_rdata,
    output logic [ROM_AW-1:0]   rom_addr,
    input  logic [DATA_W-1:0]   rom_rdata,
    output logic [CNT_W-1:0]    cycle_count,
    output logic [IDLE_W-1:0]   tick_step,
    output logic [N_TIMERS-1:0] timer_tick,
    output logic                dsp_tick
);
    bus_op_e           op;
    logic [ADDR_W-1:0] bus_addr;
    logic              mem_rd;
    logic              mem_wr;

    assign op = bus_op_e'(req_op);

    sbu_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .req_addr(req_addr), .req_dp(req_dp), .dp_page(dp_page),
        .sp_load(sp_load), .sp_value(sp_value),
        .pc_load(pc_load), .pc_value(pc_value),
        .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .sp_q(sp_q), .pc_q(pc_q)
    );

    sbu_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_AW(IO_AW), .ROM_AW(ROM_AW)) u_target (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .wdata(req_wdata),
        .rom_en_wr(rom_en_wr), .rom_en_val(rom_en_val),
        .ram_rdata(ram_rdata), .io_rdata(io_rdata), .rom_rdata(rom_rdata),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .io_sel(io_sel), .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata),
        .rom_addr(rom_addr), .rdata(rdata), .rvalid(rvalid)
    );

    sbu_cycle #(.CNT_W(CNT_W), .IDLE_W(IDLE_W), .N_TIMERS(N_TIMERS)) u_cycle (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .idle_cycles(idle_cycles), .cycle_count(cycle_count),
        .tick_step(tick_step), .timer_tick(timer_tick), .dsp_tick(dsp_tick)
    );
endmodule

// File: tb/snd_bus_unit_test.sv
module snd_bus_unit_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, req_valid, req_dp, dp_page, sp_load, pc_load, rom_en_wr, rom_en_val;
    logic [2:0]  req_op;
    logic [15:0] req_addr, pc_value;
    logic [7:0]  req_wdata, sp_value;
    logic [3:0]  idle_cycles;
    logic [7:0]  rdata, sp_q, ram_wdata, ram_rdata, io_wdata, io_rdata, rom_rdata;
    logic        rvalid, ram_we, io_sel, io_we, dsp_tick;
    logic [15:0] pc_q, ram_addr;
    logic [3:0]  io_addr, tick_step;
    logic [5:0]  rom_addr;
    logic [31:0] cycle_count;
    logic [2:0]  timer_tick;

    snd_bus_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_dp(req_dp), .req_wdata(req_wdata),
        .idle_cycles(idle_cycles), .dp_page(dp_page),
        .sp_load(sp_load), .sp_value(sp_value), .pc_load(pc_load), .pc_value(pc_value),
        .rom_en_wr(rom_en_wr), .rom_en_val(rom_en_val),
        .rdata(rdata), .rvalid(rvalid), .sp_q(sp_q), .pc_q(pc_q),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .io_sel(io_sel), .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata), .cycle_count(cycle_count),
        .tick_step(tick_step), .timer_tick(timer_tick), .dsp_tick(dsp_tick)
    );

    function automatic logic [7:0] ram_pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] io_pat(input logic [3:0] a);
        return {4'hA, a};
    endfunction
    function automatic logic [7:0] rom_pat(input logic [5:0] a);
        return {2'b11, a};
    endfunction

    assign ram_rdata = ram_pat(ram_addr);
    assign io_rdata  = io_pat(io_addr);
    assign rom_rdata = rom_pat(rom_addr);

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_cnt = 0;
    logic rom_on = 1'b1;
    logic done = 1'b0;

    // Combinational outputs captured just after driving a request.
    logic [15:0] c_addr;
    logic        c_we, c_iowe, c_iosel;
    logic [7:0]  c_wd;
    logic [3:0]  c_step;
    logic [2:0]  c_tt;
    logic        c_dsp;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [15:0] a, input logic ron);
        if (a[15:4] == 12'h00F)          return io_pat(a[3:0]);
        else if (ron && a >= 16'hFFC0)   return rom_pat(a[5:0]);
        else                             return ram_pat(a);
    endfunction

    task automatic issue(input logic [2:0] op, input logic [15:0] a, input logic dp,
                         input logic [7:0] wd, input logic [3:0] n);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_dp = dp; req_wdata = wd; idle_cycles = n;
        #1;
        c_addr = ram_addr; c_we = ram_we; c_iowe = io_we; c_iosel = io_sel; c_wd = ram_wdata;
        c_step = tick_step; c_tt = timer_tick; c_dsp = dsp_tick;
        exp_cnt = exp_cnt + ((op == 3'd0) ? 32'(n) : 32'd1);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic pulse_ctrl(input int which, input logic [15:0] v);
        @(negedge clk);
        if (which == 0) begin sp_load = 1'b1; sp_value = v[7:0]; end
        else if (which == 1) begin pc_load = 1'b1; pc_value = v; end
        else begin rom_en_wr = 1'b1; rom_en_val = v[0]; end
        @(posedge clk);
        #1;
        sp_load = 1'b0; pc_load = 1'b0; rom_en_wr = 1'b0;
    endtask

    task automatic read_at(input logic [15:0] a);
        logic [7:0] e;
        e = exp_read(a, rom_on);
        issue(3'd1, a, 1'b0, 8'h00, 4'd0);
        check(rdata == e, "R1/R2/R3 read data", 32'(rdata), 32'(e));
        check(rvalid == 1'b1, "R11 rvalid", 32'(rvalid), 1);
        check(c_iosel == (a[15:4] == 12'h00F), "R1 io_sel", 32'(c_iosel), 32'(a[15:4] == 12'h00F));
        check(!c_we && !c_iowe, "R4 no store on read", 32'(c_we), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_addr = '0; req_dp = 1'b0;
        req_wdata = '0; idle_cycles = '0; dp_page = 1'b0; sp_load = 1'b0; sp_value = '0;
        pc_load = 1'b0; pc_value = '0; rom_en_wr = 1'b0; rom_en_val = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check(rvalid == 1'b0, "R12 reset rvalid", 32'(rvalid), 0);
        check(cycle_count == 0, "R12 reset count", cycle_count, 0);
        check(sp_q == 8'hFF, "R12 reset SP", 32'(sp_q), 32'hFF);
        check(pc_q == 16'hFFC0, "R12 reset PC", 32'(pc_q), 32'hFFC0);
        read_at(16'hFFC0); // R12 ROM flag is 1 after reset

        // R1 R2 R3 R11 read sweep, ROM on then off
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) begin pulse_ctrl(2, 16'h0); rom_on = 1'b0; end
            for (int a = 0; a < 65536; a += ((a < 512 || a >= 65024) ? 1 : 7))
                read_at(16'(a));
        end
        check(cycle_count == exp_cnt, "R9 count after reads", cycle_count, exp_cnt);
        pulse_ctrl(2, 16'h1); rom_on = 1'b1; // R12 flag written back
        read_at(16'hFFFF);

        // R4 store sweep
        for (int a = 0; a < 65536; a += ((a < 512 || a >= 65472) ? 1 : 97)) begin
            logic inwin;
            inwin = (a[15:4] == 12'h00F);
            issue(3'd2, 16'(a), 1'b0, 8'(a * 3), 4'd0);
            check(c_we && c_addr == 16'(a) && c_wd == 8'(a * 3), "R4 RAM store", 32'(c_addr), 32'(a));
            check(c_iowe == inwin, "R4 io_we", 32'(c_iowe), 32'(inwin));
            check(rvalid == 1'b0, "R11 no rvalid on store", 32'(rvalid), 0);
        end

        // R5 push across the stack page wrap
        pulse_ctrl(0, 16'h0002);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] s;
            s = 8'(2 - i);
            issue(3'd3, 16'hBEEF, 1'b0, 8'(8'h30 + i), 4'd0);
            check(c_we && c_addr == {8'h01, s}, "R5 push address", 32'(c_addr), 32'({8'h01, s}));
            check(sp_q == 8'(s - 1), "R5 SP after push", 32'(sp_q), 32'(8'(s - 1)));
        end
        // R6 pop back across the wrap
        for (int i = 0; i < 4; i++) begin
            logic [7:0] s;
            s = 8'(8'hFF + i);
            issue(3'd4, 16'hBEEF, 1'b0, 8'h00, 4'd0);
            check(c_addr == {8'h01, s} && !c_we, "R6 pop address", 32'(c_addr), 32'({8'h01, s}));
            check(rdata == ram_pat({8'h01, s}) && rvalid, "R6 pop data", 32'(rdata), 32'(ram_pat({8'h01, s})));
            check(sp_q == s, "R6 SP after pop", 32'(sp_q), 32'(s));
        end

        // R7 direct page sweep, upper request byte ignored
        for (int p = 0; p < 2; p++) begin
            dp_page = p[0];
            for (int lo = 0; lo < 256; lo++) begin
                logic [15:0] ea;
                ea = {7'b0, p[0], 8'(lo)};
                issue(3'd1, {8'(lo) ^ 8'hA5, 8'(lo)}, 1'b1, 8'h00, 4'd0);
                check(c_addr == ea, "R7 direct-page address", 32'(c_addr), 32'(ea));
                check(rdata == exp_read(ea, rom_on), "R7 direct-page data", 32'(rdata), 32'(exp_read(ea, rom_on)));
            end
        end
        dp_page = 1'b0;
        issue(3'd2, 16'h77F3, 1'b1, 8'h99, 4'd0);
        check(c_addr == 16'h00F3 && c_we && c_iowe, "R7 direct-page store into I/O", 32'(c_addr), 32'h00F3);

        // R8 fetch across the PC wrap
        pulse_ctrl(1, 16'hFFFE);
        for (int i = 0; i < 3; i++) begin
            logic [15:0] pcv;
            pcv = 16'(16'hFFFE + i);
            issue(3'd5, 16'h1234, 1'b0, 8'h00, 4'd0);
            check(c_addr == pcv, "R8 fetch address", 32'(c_addr), 32'(pcv));
            check(rdata == exp_read(pcv, rom_on), "R8 fetch data", 32'(rdata), 32'(exp_read(pcv, rom_on)));
            check(pc_q == 16'(pcv + 1), "R8 PC after fetch", 32'(pc_q), 32'(16'(pcv + 1)));
        end

        // R9 single-cycle tick on an access
        issue(3'd1, 16'h4000, 1'b0, 8'h00, 4'd0);
        check(c_step == 4'd1 && c_tt == 3'b111 && c_dsp, "R9 access ticks", 32'({c_step, c_tt, c_dsp}), 32'h1F);
        check(cycle_count == exp_cnt, "R9 count", cycle_count, exp_cnt);

        // R10 idle for every count
        for (int n = 0; n < 16; n++) begin
            logic tk;
            tk = (n != 0);
            issue(3'd0, 16'h0000, 1'b0, 8'h00, 4'(n));
            check(c_step == 4'(n), "R10 idle step", 32'(c_step), 32'(n));
            check(c_tt == {3{tk}} && c_dsp == tk, "R10 idle ticks", 32'({c_tt, c_dsp}), 32'({{3{tk}}, tk}));
            check(cycle_count == exp_cnt, "R10 idle count", cycle_count, exp_cnt);
            check(!c_we && !c_iowe && !rvalid, "R4 idle no access", 32'({c_we, c_iowe, rvalid}), 0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule